// File: doc/BRIEF.md
# 16-QAM Hard-Decision Slicer

This function unit takes one real coordinate of a received symbol (either the in-phase or the quadrature component) and returns the nearest per-dimension 16-QAM level in a single clock cycle. A tree-search MIMO detector calls it during node selection. A software slicer would branch several times per call, and this unit replaces that branching with a small set of fixed comparisons. No arithmetic is done beyond comparing the input against constant decision limits.

One parameter selects the number format, and that choice holds for the life of an instance. The default is 16-bit two's-complement fixed point with 5 integer and 10 fraction bits. The alternative is a 12-bit minifloat made of a sign bit, a 4-bit biased exponent and a 7-bit mantissa. For the minifloat case, the unit decides by looking at the sign, exponent and mantissa fields directly and never converts to fixed point. The output carries the sliced level in the same format as the input, together with a 2-bit Gray-coded level index.

The unit has no controller beyond its result register. A strobe on `in_valid` loads that register. On the next cycle `out_valid` rises and the result appears. While no strobe arrives, the register keeps its previous contents.

Top module: `qam16_slicer`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high during the following cycle and `out_level`/`out_idx` carry the result for that input. When `in_valid` was low at the edge, `out_valid` is low.
- R2: While `rst_n` is low, `out_valid`, `out_level` and `out_idx` are all zero.
- R3: With x the input value, the decision regions are: x >= +2 gives +3, 0 <= x < +2 gives +1, -2 < x < 0 gives -1, and x <= -2 gives -3. A value lying exactly on +2 or -2 therefore goes to the outer level.
- R4: `out_idx` is Gray coded: 2'b00 means -3, 2'b01 means -1, 2'b11 means +1 and 2'b10 means +3. Bit 1 is set for the two non-negative levels, and bit 0 is set for the two inner levels.
- R5: In fixed-point mode the input is 16-bit two's complement scaled by 1024. The output levels are 16'h0C00 (+3), 16'h0400 (+1), 16'hFC00 (-1) and 16'hF400 (-3).
- R6: In minifloat mode the fields are: sign in bit 11, exponent in bits 10:7 with a bias of 7, and mantissa in bits 6:0 with a hidden leading one. An exponent of 0 marks a subnormal with value 0.m times 2^-6. The output levels are 12'h440 (+3), 12'h380 (+1), 12'hB80 (-1) and 12'hC40 (-3).
- R7: Any input of large magnitude clips by its sign to +3 or -3. This covers fixed-point 16'h7FFF and 16'h8000 as well as every minifloat word with exponent field 4'hF.
- R8: Zero maps to +1 in both of its minifloat encodings (12'h000 and 12'h800) and as fixed-point 16'h0000. Nonzero minifloat subnormals map to +1 or -1 according to their sign.
- R9: While `in_valid` is low, `out_level` and `out_idx` keep their last values, and changes on `in_word` do not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Loads the sample on `in_word` |
| in_word | input | WORD_W (16 fixed, 12 minifloat) | Received coordinate |
| out_valid | output | 1 | Result valid, one cycle after the load |
| out_level | output | WORD_W | Sliced level, same format as the input |
| out_idx | output | 2 | Gray-coded level index |

## Verification
The bench drives inputs exactly on +2, -2 and zero, and inputs one step to either side of each. A design with a strict comparison in the wrong place would turn +2 into +1, or send -0 or +0 to -1. It applies negative zero and subnormals in the minifloat format. A design that trusts the sign bit alone would slice negative zero to -1, and one that trusts the exponent alone would put subnormals into the wrong region. Full-scale fixed-point words and minifloat words with the all-ones exponent check that clipping never produces an out-of-range level. Sweeps across both formats compare every result against a real-valued model. A dedicated sequence checks the one-cycle latency and confirms that the output holds while no load strobe arrives.

// File: rtl/qam16_slicer_pkg.sv
package qam16_slicer_pkg;

    // Gray-coded level index: bit 1 = non-negative, bit 0 = inner level
    typedef enum logic [1:0] {
        LVL_NEG3 = 2'b00,
        LVL_NEG1 = 2'b01,
        LVL_POS1 = 2'b11,
        LVL_POS3 = 2'b10
    } qam_level_e;

    // Comparator verdict shared by both number formats
    typedef struct packed {
        logic neg;    // value strictly below zero
        logic outer;  // magnitude at or beyond the outer threshold
    } slice_region_t;

    function automatic qam_level_e region_to_level(slice_region_t r);
        return qam_level_e'({~r.neg, ~r.outer});
    endfunction

endpackage

// File: rtl/slicer_fx_cmp.sv
module slicer_fx_cmp
    import qam16_slicer_pkg::*;
#(
    parameter int INT_W  = 5,
    parameter int FRAC_W = 10,
    localparam int WORD_W = 1 + INT_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output slice_region_t     region
);
    // Thresholds +2 and -2 in the fixed-point scale
    localparam logic signed [WORD_W-1:0] POS_TWO = WORD_W'(2 << FRAC_W);
    localparam logic signed [WORD_W-1:0] NEG_TWO = -POS_TWO;

    logic signed [WORD_W-1:0] sval;

    always_comb begin
        sval         = $signed(word);
        region.neg   = sval[WORD_W-1];
        region.outer = (sval >= POS_TWO) || (sval <= NEG_TWO);
    end

endmodule

// File: rtl/slicer_mf_cmp.sv
module slicer_mf_cmp
    import qam16_slicer_pkg::*;
#(
    parameter int EXP_W = 4,
    parameter int MAN_W = 7,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] word,
    output slice_region_t     region
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    // |x| >= 2 exactly when the unbiased exponent is at least one
    localparam logic [EXP_W-1:0] OUTER_EXP = EXP_W'(BIAS + 1);

    logic             sgn;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;
    logic             is_zero;

    always_comb begin
        sgn          = word[WORD_W-1];
        expo         = word[WORD_W-2 -: EXP_W];
        man          = word[MAN_W-1:0];
        is_zero      = (expo == '0) && (man == '0);
        region.neg   = sgn && !is_zero;
        region.outer = (expo >= OUTER_EXP);
    end

endmodule

// File: rtl/slicer_level_enc.sv
module slicer_level_enc
    import qam16_slicer_pkg::*;
#(
    parameter bit USE_MINIFLOAT = 1'b0,
    parameter int EXP_W  = 4,
    parameter int MAN_W  = 7,
    parameter int INT_W  = 5,
    parameter int FRAC_W = 10,
    localparam int WORD_W = USE_MINIFLOAT ? (1 + EXP_W + MAN_W) : (1 + INT_W + FRAC_W)
) (
    input  qam_level_e        level,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] w_p3, w_p1, w_n1, w_n3;

    generate
        if (USE_MINIFLOAT) begin : g_mf
            localparam int BIAS = (1 << (EXP_W - 1)) - 1;
            localparam logic [EXP_W-1:0] E_ONE   = EXP_W'(BIAS);
            localparam logic [EXP_W-1:0] E_TWO   = EXP_W'(BIAS + 1);
            localparam logic [MAN_W-1:0] M_ONE   = '0;
            localparam logic [MAN_W-1:0] M_HALF  = MAN_W'(1 << (MAN_W - 1));
            assign w_p1 = {1'b0, E_ONE, M_ONE};
            assign w_p3 = {1'b0, E_TWO, M_HALF};
            assign w_n1 = {1'b1, E_ONE, M_ONE};
            assign w_n3 = {1'b1, E_TWO, M_HALF};
        end else begin : g_fx
            localparam logic signed [WORD_W-1:0] ONE   = WORD_W'(1 << FRAC_W);
            localparam logic signed [WORD_W-1:0] THREE = WORD_W'(3 << FRAC_W);
            assign w_p1 = ONE;
            assign w_p3 = THREE;
            assign w_n1 = -ONE;
            assign w_n3 = -THREE;
        end
    endgenerate

    always_comb begin
        unique case (level)
            LVL_POS3: word = w_p3;
            LVL_POS1: word = w_p1;
            LVL_NEG1: word = w_n1;
            LVL_NEG3: word = w_n3;
            default:  word = w_p1;
        endcase
    end

endmodule

// File: rtl/qam16_slicer.sv
module qam16_slicer
    import qam16_slicer_pkg::*;
#(
    parameter bit USE_MINIFLOAT = 1'b0,
    parameter int EXP_W  = 4,
    parameter int MAN_W  = 7,
    parameter int INT_W  = 5,
    parameter int FRAC_W = 10,
    localparam int WORD_W = USE_MINIFLOAT ? (1 + EXP_W + MAN_W) : (1 + INT_W + FRAC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_level,
    output logic [1:0]        out_idx
);
    slice_region_t     region;
    qam_level_e        next_level;
    logic [WORD_W-1:0] next_word;

    generate
        if (USE_MINIFLOAT) begin : g_cmp_mf
            slicer_mf_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
                .word   (in_word),
                .region (region)
            );
        end else begin : g_cmp_fx
            slicer_fx_cmp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cmp (
                .word   (in_word),
                .region (region)
            );
        end
    endgenerate

    always_comb begin
        next_level = region_to_level(region);
    end

    slicer_level_enc #(
        .USE_MINIFLOAT (USE_MINIFLOAT),
        .EXP_W         (EXP_W),
        .MAN_W         (MAN_W),
        .INT_W         (INT_W),
        .FRAC_W        (FRAC_W)
    ) u_enc (
        .level (next_level),
        .word  (next_word)
    );

    // Result register: loads on a strobe, otherwise holds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_level <= '0;
            out_idx   <= 2'b00;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_level <= next_word;
                out_idx   <= next_level;
            end
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_level) && $stable(out_idx)));

    generate
        if (USE_MINIFLOAT) begin : g_chk_mf
            localparam logic [EXP_W-1:0] TWO_EXP = EXP_W'((1 << (EXP_W - 1)));
            assert_clip_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_word[WORD_W-1] && (in_word[WORD_W-2 -: EXP_W] >= TWO_EXP))
                |=> (out_idx == 2'b10));
            assert_clip_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_word[WORD_W-1] && (in_word[WORD_W-2 -: EXP_W] >= TWO_EXP))
                |=> (out_idx == 2'b00));
            assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_word[WORD_W-2:0] == '0)) |=> (out_idx == 2'b11));
        end else begin : g_chk_fx
            localparam logic signed [WORD_W-1:0] CHK_TWO = WORD_W'(2 << FRAC_W);
            assert_clip_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && ($signed(in_word) >= CHK_TWO)) |=> (out_idx == 2'b10));
            assert_clip_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && ($signed(in_word) <= -CHK_TWO)) |=> (out_idx == 2'b00));
            assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_word == '0)) |=> (out_idx == 2'b11));
        end
    endgenerate

endmodule

// File: tb/qam16_slicer_test.sv
`timescale 1ns/1ps
module qam16_slicer_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        fx_vld = 1'b0;
    logic [15:0] fx_in  = '0;
    logic        fx_ov;
    logic [15:0] fx_lvl;
    logic [1:0]  fx_idx;

    logic        mf_vld = 1'b0;
    logic [11:0] mf_in  = '0;
    logic        mf_ov;
    logic [11:0] mf_lvl;
    logic [1:0]  mf_idx;

    qam16_slicer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(fx_vld), .in_word(fx_in),
        .out_valid(fx_ov), .out_level(fx_lvl), .out_idx(fx_idx)
    );

    qam16_slicer #(.USE_MINIFLOAT(1'b1)) uut_mf (
        .clk(clk), .rst_n(rst_n), .in_valid(mf_vld), .in_word(mf_in),
        .out_valid(mf_ov), .out_level(mf_lvl), .out_idx(mf_idx)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Model of R3/R4: decision regions and Gray index
    function automatic logic [1:0] model_idx(input real v);
        if (v >= 2.0)       return 2'b10;
        else if (v >= 0.0)  return 2'b11;
        else if (v > -2.0)  return 2'b01;
        else                return 2'b00;
    endfunction

    function automatic logic [15:0] fx_level(input logic [1:0] i);
        case (i)
            2'b00:   return 16'hF400;
            2'b01:   return 16'hFC00;
            2'b11:   return 16'h0400;
            default: return 16'h0C00;
        endcase
    endfunction

    function automatic logic [11:0] mf_level(input logic [1:0] i);
        case (i)
            2'b00:   return 12'hC40;
            2'b01:   return 12'hB80;
            2'b11:   return 12'h380;
            default: return 12'h440;
        endcase
    endfunction

    function automatic real fx_to_real(input logic [15:0] w);
        return $itor($signed(w)) / 1024.0;
    endfunction

    function automatic real mf_to_real(input logic [11:0] w);
        int  e;
        real f;
        real sc;
        e  = int'(w[10:7]);
        f  = (e == 0) ? ($itor(w[6:0]) / 128.0) : (1.0 + $itor(w[6:0]) / 128.0);
        if (e == 0) e = 1;
        sc = 1.0;
        if (e > 7) for (int k = 0; k < e - 7; k++) sc = sc * 2.0;
        else       for (int k = 0; k < 7 - e; k++) sc = sc / 2.0;
        return w[11] ? -(f * sc) : (f * sc);
    endfunction

    task automatic apply_fx(input logic [15:0] w, input string req);
        logic [1:0] e;
        @(negedge clk);
        fx_in  = w;
        fx_vld = 1'b1;
        @(negedge clk);
        fx_vld = 1'b0;
        e = model_idx(fx_to_real(w));
        chk(req, "fx valid", int'(fx_ov), 1);
        chk(req, "fx idx", int'(fx_idx), int'(e));
        chk(req, "fx level", int'(fx_lvl), int'(fx_level(e)));
    endtask

    task automatic apply_mf(input logic [11:0] w, input string req);
        logic [1:0] e;
        @(negedge clk);
        mf_in  = w;
        mf_vld = 1'b1;
        @(negedge clk);
        mf_vld = 1'b0;
        e = model_idx(mf_to_real(w));
        chk(req, "mf valid", int'(mf_ov), 1);
        chk(req, "mf idx", int'(mf_idx), int'(e));
        chk(req, "mf level", int'(mf_lvl), int'(mf_level(e)));
    endtask

    task automatic test_reset;
        fx_vld = 1'b1; fx_in = 16'h0C00;
        mf_vld = 1'b1; mf_in = 12'h440;
        repeat (3) @(negedge clk);
        chk("R2", "fx valid", int'(fx_ov), 0);
        chk("R2", "fx level", int'(fx_lvl), 0);
        chk("R2", "fx idx", int'(fx_idx), 0);
        chk("R2", "mf valid", int'(mf_ov), 0);
        chk("R2", "mf level", int'(mf_lvl), 0);
        fx_vld = 1'b0; mf_vld = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic test_latency_hold;
        @(negedge clk);
        fx_in = 16'hF000;   // -4 -> -3
        fx_vld = 1'b1;
        chk("R1", "fx valid before edge", int'(fx_ov), 0);
        @(negedge clk);
        fx_vld = 1'b0;
        chk("R1", "fx valid after edge", int'(fx_ov), 1);
        chk("R1", "fx idx", int'(fx_idx), 2'b00);
        fx_in = 16'h0200;   // would be +1 if loaded
        @(negedge clk);
        chk("R1", "fx valid drops", int'(fx_ov), 0);
        repeat (3) @(negedge clk);
        chk("R9", "fx idx held", int'(fx_idx), 2'b00);
        chk("R9", "fx level held", int'(fx_lvl), 16'hF400);
        mf_in = 12'h380; mf_vld = 1'b1;
        @(negedge clk);
        mf_vld = 1'b0; mf_in = 12'hC40;
        repeat (3) @(negedge clk);
        chk("R9", "mf level held", int'(mf_lvl), 12'h380);
        chk("R9", "mf idx held", int'(mf_idx), 2'b11);
    endtask

    task automatic test_fx_thresholds;
        apply_fx(16'h0800, "R3 tie +2");
        apply_fx(16'h07FF, "R3 below +2");
        apply_fx(16'h0000, "R8 zero");
        apply_fx(16'hFFFF, "R3 below 0");
        apply_fx(16'h0001, "R3 above 0");
        apply_fx(16'hF800, "R3 tie -2");
        apply_fx(16'hF801, "R3 above -2");
        chk("R4", "fx idx -1 code", int'(fx_idx), 2'b01);
        chk("R5", "fx level -1", int'(fx_lvl), 16'hFC00);
    endtask

    task automatic test_fx_extremes;
        apply_fx(16'h7FFF, "R7 max");
        chk("R7", "fx +max idx", int'(fx_idx), 2'b10);
        apply_fx(16'h8000, "R7 min");
        chk("R7", "fx -max idx", int'(fx_idx), 2'b00);
    endtask

    task automatic test_fx_sweep;
        for (int k = 0; k < 65536; k += 5) apply_fx(16'(k), "R3 R5 sweep");
    endtask

    task automatic test_mf_thresholds;
        apply_mf(12'h400, "R6 tie +2");
        apply_mf(12'h3FF, "R6 below +2");
        apply_mf(12'hC00, "R6 tie -2");
        chk("R4", "mf idx -3 code", int'(mf_idx), 2'b00);
        apply_mf(12'hBFF, "R6 above -2");
        apply_mf(12'h380, "R6 +1");
        chk("R6", "mf level +1", int'(mf_lvl), 12'h380);
    endtask

    task automatic test_mf_special;
        apply_mf(12'h800, "R8 neg zero");
        chk("R8", "mf -0 idx", int'(mf_idx), 2'b11);
        apply_mf(12'h000, "R8 pos zero");
        apply_mf(12'h801, "R8 neg subnormal");
        chk("R8", "mf -sub idx", int'(mf_idx), 2'b01);
        apply_mf(12'h07F, "R8 pos subnormal");
        apply_mf(12'h780, "R7 exp all ones");
        chk("R7", "mf +inf idx", int'(mf_idx), 2'b10);
        apply_mf(12'hFFF, "R7 neg all ones");
        chk("R7", "mf -nan idx", int'(mf_idx), 2'b00);
    endtask

    task automatic test_mf_sweep;
        for (int k = 0; k < 4096; k++) apply_mf(12'(k), "R6 sweep");
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000 && !finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        test_reset();
        test_latency_hold();
        test_fx_thresholds();
        test_fx_extremes();
        test_mf_thresholds();
        test_mf_special();
        test_fx_sweep();
        test_mf_sweep();
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule